// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects the interrupt requests of a small 8-bit microcontroller and hands the CPU one request at a time, together with a vector number. It serves two external pin sources, a group of internal peripheral requests and a non-maskable input. The external pins are synchronised. Pin source 1 can be sensed by level or by edge. Pin source 2 has a programmable edge polarity. Peripheral requests are level inputs, and each one is gated by a mask bit supplied by its peripheral.

Software programs the block through one write-only option register on the peripheral bus. That register holds the source-1 sensing mode, the source-2 polarity and a global enable. The CPU takes a request by pulsing an acknowledge. This clears the latched edge of the vector that was served and, for a maskable vector, marks the controller as in service until the CPU signals return from interrupt. A wake-up output tells the power controller to leave the STOP or WAIT state.

Top module: `irq_ctrl`

## Requirements
- R1: The option register is written only when `bus_we_i` is high and `bus_addr_i` equals C8h. Writes to any other address have no effect. Only bit 6 (source-1 level mode), bit 5 (source-2 rising polarity) and bit 4 (global enable) are stored. After reset all three are zero.
- R2: While global enable (bit 4) is 0, no maskable request makes `irq_o` high.
- R3: With bit 6 = 1, source 1 requests vector 1 for as long as its synchronised pin is high. The request drops when the pin goes low, with no acknowledge.
- R4: With bit 6 = 0, a rising edge on the source-1 pin latches a vector-1 request. The request stays after the pin returns low, until it is acknowledged.
- R5: Source 2 latches a vector-2 request on a rising edge when bit 5 = 1, and on a falling edge when bit 5 = 0. The opposite edge is ignored.
- R6: Bit i of `periph_req_i` counts only when bit i of `periph_en_i` is set. Bit 0 is timer overflow and bit 4 is end of conversion; both go to vector 4. Bits 1 to 3 are auto-reload overflow, compare match and capture edge; these go to vector 3.
- R7: Fixed priority, highest first: NMI (vector 0), then vector 1, 2, 3 and 4. `irq_vec_o` shows the highest pending request.
- R8: An acknowledge (`irq_ack_i` high while `irq_o` is high) clears the latched request of the presented vector. After a maskable vector is acknowledged, no maskable request is presented until `irq_ret_i` is pulsed.
- R9: A rising edge on `nmi_i` latches a vector-0 request. This request is presented regardless of the global enable and of the in-service state, and an acknowledge clears it.
- R10: `wake_o` is high when the global enable is 1 and any enabled request, NMI included, is pending. It is low whenever the global enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Peripheral bus write strobe |
| bus_addr_i | input | 8 | Peripheral bus address |
| bus_wdata_i | input | 8 | Peripheral bus write data |
| pin1_i | input | 1 | External interrupt pin, source 1 |
| pin2_i | input | 1 | External interrupt pin, source 2 |
| nmi_i | input | 1 | Non-maskable interrupt pin, rising edge active |
| periph_req_i | input | 5 | Peripheral request flags |
| periph_en_i | input | 5 | Peripheral mask bits, 1 = enabled |
| irq_ack_i | input | 1 | CPU acknowledge of the presented request |
| irq_ret_i | input | 1 | CPU return-from-interrupt pulse |
| irq_o | output | 1 | A request is presented |
| irq_vec_o | output | 3 | Vector number of the presented request |
| wake_o | output | 1 | Wake-up request for STOP and WAIT modes |

## Verification
The bench checks four corner cases.

- NMI with the global enable off. A design that gated NMI with the enable would miss the vector, and one that let NMI wake the chip would raise `wake_o`.
- Edge latching. A request that still follows the pin after it falls shows that edge mode was built as level mode. A source-2 request on the wrong edge shows that the polarity is inverted.
- The in-service window. A maskable request that appears before the return pulse, or an acknowledged edge that appears again afterwards, shows a broken handshake.
- Priority. Random peripheral patterns and simultaneous pin events expose a wrong order or a wrong vector-3/vector-4 grouping.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [7:0] OPT_ADDR = 8'hC8;
  localparam int BIT_LVL1 = 6;
  localparam int BIT_POL2 = 5;
  localparam int BIT_GEN  = 4;
  localparam int NUM_VEC  = 5;
  localparam int VEC_W    = $clog2(NUM_VEC);

  typedef struct packed {
    logic lvl1;
    logic pol2;
    logic gen;
  } opt_t;
endpackage

// File: rtl/irq_opt_reg.sv
module irq_opt_reg
  import irq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output opt_t          opt_o
);
  logic hit;
  assign hit = we_i && (addr_i == AW'(OPT_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) opt_o <= '0;
    else if (hit) begin
      opt_o.lvl1 <= wdata_i[BIT_LVL1];
      opt_o.pol2 <= wdata_i[BIT_POL2];
      opt_o.gen  <= wdata_i[BIT_GEN];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{wdata_i[7], wdata_i[3:0]};

  // R1: a write that does not hit the register leaves it unchanged
  a_r1_write_only_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(opt_o));
endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic level_i,
  input  logic rising_i,
  input  logic clr_i,
  output logic req_o
);
  logic [STAGES-1:0] sync_q;
  logic prev_q, pend_q, smp, edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign smp      = sync_q[STAGES-1];
  assign edge_hit = rising_i ? (smp & ~prev_q) : (~smp & prev_q);

  // a new edge wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (level_i)   pend_q <= 1'b0;
    else if (edge_hit)  pend_q <= 1'b1;
    else if (clr_i)     pend_q <= 1'b0;
  end

  assign req_o = level_i ? smp : pend_q;

  // R4: a latched edge holds until cleared
  a_r4_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i && !level_i |=> pend_q);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_pkg::*;
#(
  parameter int N = NUM_VEC
) (
  input  logic             nmi_req_i,
  input  logic [N-1:1]     mreq_i,
  input  logic             gen_i,
  input  logic             in_svc_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    irq_o = 1'b0;
    vec_o = '0;
    if (nmi_req_i) begin
      irq_o = 1'b1;
    end else if (gen_i && !in_svc_i) begin
      for (int i = N - 1; i >= 1; i--) begin
        if (mreq_i[i]) begin
          irq_o = 1'b1;
          vec_o = VEC_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int AW          = 8,
  parameter int PER_N       = 5,
  parameter int SYNC_STAGES = 2,
  parameter logic [PER_N-1:0] VEC3_MASK = 5'b01110,
  parameter logic [PER_N-1:0] VEC4_MASK = 5'b10001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [7:0]       bus_wdata_i,
  input  logic             pin1_i,
  input  logic             pin2_i,
  input  logic             nmi_i,
  input  logic [PER_N-1:0] periph_req_i,
  input  logic [PER_N-1:0] periph_en_i,
  input  logic             irq_ack_i,
  input  logic             irq_ret_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             wake_o
);
  opt_t opt;
  logic [NUM_VEC-1:0] clr;
  logic [NUM_VEC-1:1] mreq;
  logic [PER_N-1:0]   per_act;
  logic nmi_req, ack_fire, in_svc_q;

  irq_opt_reg #(.AW(AW)) u_opt (
    .clk_i, .rst_ni, .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .opt_o(opt)
  );

  assign ack_fire = irq_ack_i && irq_o;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_clr
    assign clr[v] = ack_fire && (irq_vec_o == VEC_W'(v));
  end

  irq_pin_detect #(.STAGES(SYNC_STAGES)) u_nmi (
    .clk_i, .rst_ni, .pin_i(nmi_i), .level_i(1'b0), .rising_i(1'b1),
    .clr_i(clr[0]), .req_o(nmi_req)
  );
  irq_pin_detect #(.STAGES(SYNC_STAGES)) u_src1 (
    .clk_i, .rst_ni, .pin_i(pin1_i), .level_i(opt.lvl1), .rising_i(1'b1),
    .clr_i(clr[1]), .req_o(mreq[1])
  );
  irq_pin_detect #(.STAGES(SYNC_STAGES)) u_src2 (
    .clk_i, .rst_ni, .pin_i(pin2_i), .level_i(1'b0), .rising_i(opt.pol2),
    .clr_i(clr[2]), .req_o(mreq[2])
  );

  assign per_act = periph_req_i & periph_en_i;
  assign mreq[3] = |(per_act & VEC3_MASK);
  assign mreq[4] = |(per_act & VEC4_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   in_svc_q <= 1'b0;
    else if (ack_fire && irq_vec_o != '0)          in_svc_q <= 1'b1;
    else if (irq_ret_i)                            in_svc_q <= 1'b0;
  end

  irq_prio_arb #(.N(NUM_VEC)) u_arb (
    .nmi_req_i(nmi_req), .mreq_i(mreq), .gen_i(opt.gen),
    .in_svc_i(in_svc_q), .irq_o, .vec_o(irq_vec_o)
  );

  assign wake_o = opt.gen && (nmi_req || |mreq);

  a_r2_gen_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opt.gen && !nmi_req |-> !irq_o);
  a_r10_no_wake_gen_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opt.gen |-> !wake_o);
  a_r8_svc_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc_q && !nmi_req |-> !irq_o);
  a_r8_svc_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire && irq_vec_o != '0 |=> in_svc_q);
  a_r9_nmi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req |-> irq_o && irq_vec_o == '0);
  a_r7_vec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_vec_o < VEC_W'(NUM_VEC));
endmodule

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic pin1 = 1'b0, pin2 = 1'b0, nmi = 1'b0;
  logic [4:0] preq = '0, pen = '0;
  logic ack = 1'b0, ret = 1'b0;
  logic irq, wake;
  logic [2:0] vec;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .pin1_i(pin1), .pin2_i(pin2), .nmi_i(nmi),
    .periph_req_i(preq), .periph_en_i(pen), .irq_ack_i(ack),
    .irq_ret_i(ret), .irq_o(irq), .irq_vec_o(vec), .wake_o(wake)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
  endtask

  // expected vector for peripheral-only patterns (R6, R7): -1 = none
  function automatic int exp_per(logic [4:0] r, logic [4:0] e);
    logic [4:0] a = r & e;
    if (|(a & 5'b01110)) return 3;
    if (|(a & 5'b10001)) return 4;
    return -1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    step(3); rst_n = 1'b1; step(1);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset wake", int'(wake), 0);

    preq = 5'b00001; pen = 5'b00001; step(2);
    chk("R2 gen off irq", int'(irq), 0);
    chk("R10 gen off wake", int'(wake), 0);
    wr(8'hC9, 8'h10); step(1);
    chk("R1 wrong addr", int'(irq), 0);
    wr(8'hC8, 8'h9F); step(1);
    chk("R1 gen set irq", int'(irq), 1);
    chk("R6 timer vec4", int'(vec), 4);
    chk("R10 wake", int'(wake), 1);
    pen = 5'b0; step(1);
    chk("R6 masked", int'(irq), 0);

    for (int i = 0; i < 100; i++) begin
      int e;
      preq = 5'($urandom); pen = 5'($urandom); step(1);
      e = exp_per(preq, pen);
      chk("R7 rand irq", int'(irq), e >= 0 ? 1 : 0);
      if (e >= 0) chk("R6 rand vec", int'(vec), e);
      chk("R10 rand wake", int'(wake), e >= 0 ? 1 : 0);
    end
    preq = '0; pen = '0;

    wr(8'hC8, 8'h50);
    pin1 = 1'b1; step(4);
    chk("R3 level irq", int'(irq), 1);
    chk("R3 level vec", int'(vec), 1);
    pin1 = 1'b0; step(4);
    chk("R3 level drop", int'(irq), 0);

    wr(8'hC8, 8'h10);
    pin1 = 1'b1; step(2); pin1 = 1'b0; step(4);
    chk("R4 edge latched", int'(irq), 1);
    chk("R4 edge vec", int'(vec), 1);
    do_ack(); step(1);
    chk("R8 cleared by ack", int'(irq), 0);
    preq = 5'b10000; pen = 5'b10000; step(2);
    chk("R8 in service blocks", int'(irq), 0);
    do_ret(); step(1);
    chk("R8 after ret irq", int'(irq), 1);
    chk("R8 after ret vec", int'(vec), 4);
    preq = '0; pen = '0; step(1);
    chk("R8 edge not repeated", int'(irq), 0);

    wr(8'hC8, 8'h30);
    pin2 = 1'b1; step(4);
    chk("R5 rising vec", int'(vec), 2);
    chk("R5 rising irq", int'(irq), 1);
    do_ack(); do_ret();
    pin2 = 1'b0; step(4);
    chk("R5 falling ignored", int'(irq), 0);
    wr(8'hC8, 8'h10);
    pin2 = 1'b1; step(4);
    chk("R5 rising ignored", int'(irq), 0);
    pin2 = 1'b0; step(4);
    chk("R5 falling irq", int'(irq), 1);
    chk("R5 falling vec", int'(vec), 2);
    do_ack(); do_ret();

    wr(8'hC8, 8'h30);
    pin1 = 1'b1; pin2 = 1'b1; step(2); pin1 = 1'b0; step(4);
    chk("R7 src1 over src2", int'(vec), 1);
    do_ack(); do_ret(); step(1);
    chk("R7 then src2", int'(vec), 2);
    chk("R7 then src2 irq", int'(irq), 1);
    do_ack(); do_ret(); pin2 = 1'b0; step(4);
    chk("R7 all served", int'(irq), 0);

    wr(8'hC8, 8'h00);
    nmi = 1'b1; step(4);
    chk("R9 nmi gen off", int'(irq), 1);
    chk("R9 nmi vec", int'(vec), 0);
    chk("R10 nmi no wake", int'(wake), 0);
    do_ack(); step(1);
    chk("R9 nmi cleared", int'(irq), 0);
    nmi = 1'b0;

    wr(8'hC8, 8'h10);
    preq = 5'b00100; pen = 5'b00100; step(1);
    chk("R6 compare vec3", int'(vec), 3);
    do_ack(); step(1);
    chk("R8 svc blocks vec3", int'(irq), 0);
    nmi = 1'b1; step(4);
    chk("R9 nmi preempts", int'(irq), 1);
    chk("R9 preempt vec", int'(vec), 0);
    chk("R10 nmi wake", int'(wake), 1);
    do_ack(); step(1);
    chk("R9 nmi served", int'(irq), 0);
    do_ret(); step(1);
    chk("R8 resume vec3", int'(vec), 3);
    chk("R8 resume irq", int'(irq), 1);
    preq = '0; pen = '0; nmi = 1'b0; step(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule